// File: doc/BRIEF.md
# Flash Query-Mode Command Controller

This block holds the command logic of a banked NOR flash that can report its own identification data. A host drives a 16-bit word bus with a bank index and a word offset, using one write strobe and one read strobe. In normal operation every read returns array data. The block models the array as a fixed pattern for each bank. The host puts one bank into query mode by writing command 0098h to offset 555h of that bank. While a bank is in query mode, reads inside that bank come from a small identification table. Reads from the other banks still return array data, and writes to the other banks are refused. Writing command 00F0h to the query bank returns it to array reads.

The controller is a two-state machine with states ST_ARRAY and ST_QUERY, plus a register that holds the bank in query mode. Three transitions exist:
- T_ENTER goes from ST_ARRAY to ST_QUERY. It is taken when 0098h is written to offset 555h, and it stores the bank index.
- T_EXIT goes from ST_QUERY to ST_ARRAY. It is taken when 00F0h is written to the stored bank.
- T_HOLD keeps the current state for every other cycle.

Read data passes through one register stage. A read_valid pulse marks it. When a read falls inside the query bank but outside the table window, the block also raises a data_invalid pulse.

Top module: `cfi_query_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in ST_ARRAY, clears the stored bank to 0, and drives rdata to 0000h and read_valid and data_invalid to 0. After reset, reads return array words.
- R2: In ST_ARRAY, a write of 0098h to offset 555h of bank b takes T_ENTER. Later reads of bank b at offset 10h return 0051h.
- R3: In ST_QUERY, reads of the query bank at offsets 10h, 11h and 12h return 0051h, 0052h and 0059h, which spell "QRY".
- R4: The table window covers offsets 10h to 3Fh. Offset 13h returns 0002h (primary command set) and offset 15h returns 0040h (primary extended table address). Offset 1Bh returns 0017h, a minimum supply voltage of 1.7 V: volts are in bits 7-4 and tenths of a volt in bits 3-0. Window offsets with no defined entry, such as 3Fh, return 0000h with data_invalid low.
- R5: A read of the query bank at an offset outside 10h-3Fh returns 0000h, with data_invalid high for that one result.
- R6: While one bank is in ST_QUERY, reads of any other bank return the array word.
- R7: While one bank is in ST_QUERY, writes to any other bank are ignored. A 0098h written to offset 555h of another bank does not move query mode, and 00F0h written to another bank does not end it.
- R8: A write of 00F0h to the query bank, at any offset, takes T_EXIT. After that, reads of that bank return array words.
- R9: Any other write to the query bank, including 0098h written to offset 555h, leaves the state and the stored bank unchanged.
- R10: rdata and read_valid appear in the cycle after rd_en is sampled, and back-to-back reads give one result per cycle. The array word for bank b at offset o is o XOR (b shifted left by 12) XOR C000h, in 16 bits.
- R11: In ST_ARRAY, a write of 0098h to any offset other than 555h does not enter query mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one command word per cycle |
| rd_en | input | 1 | Read strobe |
| bank | input | BANK_W | Bank index of the access |
| offset | input | OFF_W | Word offset within the bank |
| wdata | input | DATA_W | Write data (command word) |
| rdata | output | DATA_W | Registered read data |
| read_valid | output | 1 | Pulses one cycle after each read strobe |
| data_invalid | output | 1 | Pulses with a result that lies outside the query window |

## Verification
The bench targets the edges of the table window: offsets 0Fh, 40h and 555h in the query bank. A wrong window decode would return table or array data there with no invalid flag, or would flag 3Fh as invalid. It sends the entry command to a wrong offset, and sends both commands to a bank other than the query bank. A controller that does not check the offset, or does not compare the bank, would then move or drop query mode, and later reads would give array words where table words are expected, or the reverse. It also writes noise to the query bank, and it resets the block while query mode is active. A design that treats any write as an exit, or that does not clear the mode on reset, returns the wrong data on the reads that follow.

// File: rtl/cfi_query_pkg.sv
package cfi_query_pkg;

    // Command words recognised on the write bus
    localparam logic [15:0] CMD_ENTER_QUERY = 16'h0098;
    localparam logic [15:0] CMD_EXIT_QUERY  = 16'h00F0;

    // Word offset at which the entry command must land
    localparam logic [11:0] ENTER_OFFSET = 12'h555;

    // Query table window, inclusive bounds
    localparam logic [11:0] WIN_FIRST = 12'h010;
    localparam logic [11:0] WIN_LAST  = 12'h03F;

    // Base pattern mixed into every modelled array word
    localparam logic [15:0] ARRAY_BASE = 16'hC000;

    typedef enum logic [0:0] {
        ST_ARRAY = 1'b0,
        ST_QUERY = 1'b1
    } cfi_state_e;

    typedef enum logic [1:0] {
        T_HOLD  = 2'd0,
        T_ENTER = 2'd1,
        T_EXIT  = 2'd2
    } cfi_trans_e;

endpackage

// File: rtl/cfi_cmd_fsm.sv
module cfi_cmd_fsm
    import cfi_query_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic              q_active,
    output logic [BANK_W-1:0] q_bank
);

    localparam logic [DATA_W-1:0] ENTER_W = DATA_W'(CMD_ENTER_QUERY);
    localparam logic [DATA_W-1:0] EXIT_W  = DATA_W'(CMD_EXIT_QUERY);
    localparam logic [OFF_W-1:0]  ENTER_O = OFF_W'(ENTER_OFFSET);

    cfi_state_e        state_q, state_d;
    cfi_trans_e        trans;
    logic [BANK_W-1:0] bank_q, bank_d;

    logic is_enter_cmd;
    logic is_exit_cmd;
    logic hits_q_bank;

    assign is_enter_cmd = wr_en && (wdata == ENTER_W) && (offset == ENTER_O);
    assign is_exit_cmd  = wr_en && (wdata == EXIT_W);
    assign hits_q_bank  = (bank == bank_q);

    // Transition selection
    always_comb begin
        trans = T_HOLD;
        unique case (state_q)
            ST_ARRAY: begin
                if (is_enter_cmd) trans = T_ENTER;
            end
            ST_QUERY: begin
                if (is_exit_cmd && hits_q_bank) trans = T_EXIT;
            end
            default: trans = T_HOLD;
        endcase
    end

    // Next state and stored bank
    always_comb begin
        state_d = state_q;
        bank_d  = bank_q;
        unique case (trans)
            T_ENTER: begin
                state_d = ST_QUERY;
                bank_d  = bank;
            end
            T_EXIT: begin
                state_d = ST_ARRAY;
            end
            T_HOLD: begin
                state_d = state_q;
            end
            default: state_d = state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARRAY;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
        end
    end

    // Outputs
    always_comb begin
        q_active = (state_q == ST_QUERY);
        q_bank   = bank_q;
    end

endmodule

// File: rtl/cfi_id_rom.sv
module cfi_id_rom
    import cfi_query_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic [OFF_W-1:0]  offset,
    output logic              in_window,
    output logic [DATA_W-1:0] word
);

    localparam logic [OFF_W-1:0] LO = OFF_W'(WIN_FIRST);
    localparam logic [OFF_W-1:0] HI = OFF_W'(WIN_LAST);

    // Identification table, indexed by the low six offset bits
    function automatic logic [15:0] id_entry(input logic [5:0] idx);
        logic [15:0] v;
        unique case (idx)
            6'h10: v = 16'h0051;  // 'Q'
            6'h11: v = 16'h0052;  // 'R'
            6'h12: v = 16'h0059;  // 'Y'
            6'h13: v = 16'h0002;  // primary command set
            6'h14: v = 16'h0000;
            6'h15: v = 16'h0040;  // primary extended table address
            6'h16: v = 16'h0000;
            6'h17: v = 16'h0000;  // no alternate set
            6'h18: v = 16'h0000;
            6'h19: v = 16'h0000;
            6'h1A: v = 16'h0000;
            6'h1B: v = 16'h0017;  // supply min, 1.7 V
            6'h1C: v = 16'h0019;  // supply max, 1.9 V
            6'h1D: v = 16'h0000;  // no program supply pin
            6'h1E: v = 16'h0000;
            6'h1F: v = 16'h0003;  // word write, 2^3 us typical
            6'h20: v = 16'h0000;  // buffer write not supported
            6'h21: v = 16'h0009;  // block erase, 2^9 ms typical
            6'h22: v = 16'h0000;  // chip erase not supported
            6'h23: v = 16'h0004;  // word write max, 2^4 x typical
            6'h24: v = 16'h0000;
            6'h25: v = 16'h0004;  // block erase max, 2^4 x typical
            6'h26: v = 16'h0000;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

    always_comb begin
        in_window = (offset >= LO) && (offset <= HI);
        word      = in_window ? DATA_W'(id_entry(offset[5:0])) : '0;
    end

endmodule

// File: rtl/cfi_array_model.sv
module cfi_array_model
    import cfi_query_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] word
);

    localparam logic [DATA_W-1:0] BASE = DATA_W'(ARRAY_BASE);

    logic [DATA_W-1:0] bank_word [BANKS];

    // One pattern generator per bank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_word[b] = DATA_W'(offset) ^ (DATA_W'(b) << 12) ^ BASE;
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < BANKS; i++) begin
            if (bank == BANK_W'(i)) word = bank_word[i];
        end
    end

endmodule

// File: rtl/cfi_query_ctrl.sv
module cfi_query_ctrl
    import cfi_query_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 16,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              read_valid,
    output logic              data_invalid
);

    logic              q_active;
    logic [BANK_W-1:0] q_bank;
    logic              rom_hit;
    logic [DATA_W-1:0] rom_word;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] rd_word;
    logic              rd_bad;

    cfi_cmd_fsm #(
        .BANK_W (BANK_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .bank     (bank),
        .offset   (offset),
        .wdata    (wdata),
        .q_active (q_active),
        .q_bank   (q_bank)
    );

    cfi_id_rom #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_rom (
        .offset    (offset),
        .in_window (rom_hit),
        .word      (rom_word)
    );

    cfi_array_model #(
        .BANKS  (BANKS),
        .BANK_W (BANK_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_array (
        .bank   (bank),
        .offset (offset),
        .word   (arr_word)
    );

    // Read source selection against the mode held before this cycle's write
    always_comb begin
        if (q_active && (bank == q_bank)) begin
            rd_word = rom_hit ? rom_word : '0;
            rd_bad  = !rom_hit;
        end else begin
            rd_word = arr_word;
            rd_bad  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata        <= '0;
            read_valid   <= 1'b0;
            data_invalid <= 1'b0;
        end else begin
            read_valid   <= rd_en;
            data_invalid <= rd_en && rd_bad;
            if (rd_en) rdata <= rd_word;
        end
    end

endmodule

// File: rtl/cfi_query_chk.sv
module cfi_query_chk
    import cfi_query_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BANK_W-1:0] bank,
    input logic [OFF_W-1:0]  offset,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              read_valid,
    input logic              data_invalid,
    input logic              q_active,
    input logic [BANK_W-1:0] q_bank
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!q_active && q_bank == '0 && !read_valid && !data_invalid && rdata == '0));

    // R2
    enter_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_active && wr_en && wdata == DATA_W'(CMD_ENTER_QUERY) && offset == OFF_W'(ENTER_OFFSET))
        |=> (q_active && q_bank == $past(bank)));

    // R11
    wrong_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_active && wr_en && offset != OFF_W'(ENTER_OFFSET)) |=> !q_active);

    // R5
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        data_invalid |-> (read_valid && rdata == '0));

    // R7
    other_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (q_active && wr_en && bank != q_bank) |=> (q_active && $stable(q_bank)));

    // R8
    exit_chk: assert property (@(posedge clk) disable iff (rst)
        (q_active && wr_en && bank == q_bank && wdata == DATA_W'(CMD_EXIT_QUERY)) |=> !q_active);

    // R9
    noise_chk: assert property (@(posedge clk) disable iff (rst)
        (q_active && wr_en && bank == q_bank && wdata != DATA_W'(CMD_EXIT_QUERY))
        |=> (q_active && $stable(q_bank)));

    // R10
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> read_valid);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !read_valid);

endmodule

bind cfi_query_ctrl cfi_query_chk #(
    .BANK_W (BANK_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
) chk_i (.*);

// File: tb/cfi_query_ctrl_test.sv
module cfi_query_ctrl_test;

    localparam int BANKS  = 4;
    localparam int BANK_W = 2;
    localparam int OFF_W  = 12;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [BANK_W-1:0] bank = '0;
    logic [OFF_W-1:0]  offset = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              read_valid;
    logic              data_invalid;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              bad;
        string             req;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;  // 125 MHz

    cfi_query_ctrl #(.BANKS(BANKS), .OFF_W(OFF_W), .DATA_W(DATA_W)) uut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .bank         (bank),
        .offset       (offset),
        .wdata        (wdata),
        .rdata        (rdata),
        .read_valid   (read_valid),
        .data_invalid (data_invalid)
    );

    function automatic logic [DATA_W-1:0] arr(input int b, input int o);
        return DATA_W'(o) ^ DATA_W'(b << 12) ^ 16'hC000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Driver: one read per call, expected item pushed first
    task automatic rd(input int b, input int o, input logic [DATA_W-1:0] e,
                      input logic bad, input string req);
        exp_t it;
        it.data = e; it.bad = bad; it.req = req;
        exp_q.push_back(it);
        @(negedge clk);
        rd_en = 1'b1; bank = BANK_W'(b); offset = OFF_W'(o);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input int b, input int o, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; bank = BANK_W'(b); offset = OFF_W'(o); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compare each result against the scoreboard head
    always @(negedge clk) begin
        if (!rst && read_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected result", 32'(read_valid), 32'd0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check({it.req, " data"}, 32'(rdata), 32'(it.data));
                check({it.req, " invalid flag"}, 32'(data_invalid), 32'(it.bad));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check("R1 rdata", 32'(rdata), 32'd0);
        check("R1 read_valid", 32'(read_valid), 32'd0);
        check("R1 data_invalid", 32'(data_invalid), 32'd0);
        rd(0, 'h10, arr(0, 'h10), 1'b0, "R1");

        // R10: array words, back-to-back reads
        exp_q.push_back('{arr(3, 'h123), 1'b0, "R10"});
        exp_q.push_back('{arr(1, 'h7FF), 1'b0, "R10"});
        @(negedge clk);
        rd_en = 1'b1; bank = 2'd3; offset = 12'h123;
        @(negedge clk);
        bank = 2'd1; offset = 12'h7FF;
        @(negedge clk);
        rd_en = 1'b0;

        // R11: entry command at a wrong offset
        wr(2, 'h554, 16'h0098);
        rd(2, 'h10, arr(2, 'h10), 1'b0, "R11");

        // R2, R3, R4, R5, R6
        wr(2, 'h555, 16'h0098);
        rd(2, 'h10, 16'h0051, 1'b0, "R3");
        rd(2, 'h11, 16'h0052, 1'b0, "R3");
        rd(2, 'h12, 16'h0059, 1'b0, "R3");
        rd(2, 'h13, 16'h0002, 1'b0, "R4");
        rd(2, 'h15, 16'h0040, 1'b0, "R4");
        rd(2, 'h1B, 16'h0017, 1'b0, "R4");
        rd(2, 'h3F, 16'h0000, 1'b0, "R4");
        rd(2, 'h0F, 16'h0000, 1'b1, "R5");
        rd(2, 'h40, 16'h0000, 1'b1, "R5");
        rd(2, 'h555, 16'h0000, 1'b1, "R5");
        rd(1, 'h10, arr(1, 'h10), 1'b0, "R6");
        rd(0, 'h40, arr(0, 'h40), 1'b0, "R6");

        // R7: commands to other banks refused
        wr(1, 'h555, 16'h0098);
        rd(1, 'h10, arr(1, 'h10), 1'b0, "R7");
        rd(2, 'h10, 16'h0051, 1'b0, "R7");
        wr(3, 'h000, 16'h00F0);
        rd(2, 'h11, 16'h0052, 1'b0, "R7");

        // R9: noise to the query bank
        wr(2, 'h010, 16'h0055);
        wr(2, 'h555, 16'h0098);
        rd(2, 'h12, 16'h0059, 1'b0, "R9");

        // R8: exit at a non-zero offset, then R2 on another bank
        wr(2, 'h2AA, 16'h00F0);
        rd(2, 'h10, arr(2, 'h10), 1'b0, "R8");
        wr(1, 'h555, 16'h0098);
        rd(1, 'h10, 16'h0051, 1'b0, "R2");
        rd(2, 'h10, arr(2, 'h10), 1'b0, "R2");

        // R1: reset during query mode
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(1, 'h10, arr(1, 'h10), 1'b0, "R1");

        repeat (3) @(negedge clk);
        check("R10 all results returned", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule